// File: doc/BRIEF.md
# Loop Stream Detector

This block sits beside an instruction decode queue and watches every µop written into it. Each µop comes with a few tags: the index of the 16-byte fetch block it was decoded from, whether it is a taken branch, whether that branch is a return, and whether the µop begins a loop body. A taken non-return branch that is immediately followed by a µop carrying the loop-start tag is treated as a backward branch that closes a loop.

From the first closure on, the block counts µops, fetch blocks and taken branches in the body. The same closing branch must come round again with every limit still met. A body that breaks a limit is dropped at once, and tracking starts again only at the next closure. When the same branch closes a qualifying body a set number of times in a row, the block locks. It raises a gate that stalls fetch and decode, and it replays the captured body from its own µop store in program order, over and over. A flush, caused by a mispredict or a loop exit, releases the lock in the same cycle and clears all tracking state.

Top module: `loop_stream_detector`

## Requirements
- R1: A body whose µops span more than MAX_BLOCKS (default 4) fetch blocks never locks. The span is one for the loop-start µop, plus one for every following µop whose block index differs from that of the µop written before it.
- R2: A body of more than MAX_UOPS (default 28) µops, counting from the loop-start µop through the closing branch, never locks. A body of exactly 28 µops does lock.
- R3: A body with more than MAX_TAKEN (default 4) taken branches never locks. The count includes the closing branch, and a body with exactly 4 does lock.
- R4: A taken return anywhere in the body abandons tracking, so that body never locks.
- R5: A closure is a write with the loop-start tag whose previous write was a taken non-return branch. The first closure starts tracking. Each later closure by the same branch, identified by its fetch-block index, after a qualifying body counts one pass. The lock is taken on the write that completes pass number LOCK_ITERS (default 2), and not before.
- R6: While locked, gate_o and replay_valid_o are 1, and µop writes are ignored: they alter neither the replayed sequence nor the lock.
- R7: Replay begins with the loop-start µop in the first locked cycle, presents one µop per cycle in body order, and wraps from the closing branch back to the loop-start µop.
- R8: flush_i forces gate_o and replay_valid_o to 0 in the same cycle, and clears all tracking state. After a flush, the full detection sequence is needed again before the next lock.
- R9: After reset, gate_o and replay_valid_o are 0.
- R10: A closure by a different branch than the one being tracked restarts the pass count for that new branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Mispredict or loop exit; unlocks and clears |
| uop_valid_i | input | 1 | A µop is written into the queue this cycle |
| uop_i | input | UOP_W | µop payload |
| uop_blk_i | input | BLK_W | Fetch-block index of the µop |
| uop_taken_i | input | 1 | µop is a taken branch |
| uop_ret_i | input | 1 | Branch is a return |
| uop_tgt_i | input | 1 | µop is the first of a loop body (branch target) |
| gate_o | output | 1 | Stall fetch and decode |
| replay_valid_o | output | 1 | replay_uop_o carries a replayed µop |
| replay_uop_o | output | UOP_W | Replayed µop |

## Verification
The assertions assume that the front end sets the loop-start tag only on the first µop after a backward redirect, and that it stops writing once the gate is raised. If writes continue during a lock, the design ignores them. The assertions also assume that the replay consumer takes one µop every cycle. The stimulus builds every body from a single generator: the loop-start tag sits on µop 0, inner taken branches sit strictly before the closing branch, and block indices rise monotonically, so the span is known exactly. The random writes issued during a lock check that such writes are ignored.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_LOCK} lsd_state_e;
endpackage

// File: rtl/lsd_track.sv
module lsd_track
  import lsd_pkg::*;
#(
  parameter int MAX_UOPS   = 28,
  parameter int MAX_BLOCKS = 4,
  parameter int MAX_TAKEN  = 4,
  parameter int LOCK_ITERS = 2,
  parameter int BLK_W      = 8,
  parameter int IDX_W      = $clog2(MAX_UOPS),
  parameter int UC_W       = $clog2(MAX_UOPS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             uop_valid_i,
  input  logic [BLK_W-1:0] uop_blk_i,
  input  logic             uop_taken_i,
  input  logic             uop_ret_i,
  input  logic             uop_tgt_i,
  output logic             lock_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [UC_W-1:0]  len_o
);
  localparam int BC_W = $clog2(MAX_BLOCKS + 2);
  localparam int TC_W = $clog2(MAX_TAKEN + 2);
  localparam int IT_W = $clog2(LOCK_ITERS + 1);
  localparam logic [UC_W-1:0] U_LIM  = UC_W'(MAX_UOPS);
  localparam logic [BC_W-1:0] B_LIM  = BC_W'(MAX_BLOCKS);
  localparam logic [TC_W-1:0] T_LIM  = TC_W'(MAX_TAKEN);
  localparam logic [IT_W-1:0] IT_LIM = IT_W'(LOCK_ITERS);

  lsd_state_e       state_q;
  logic             pend_q;
  logic [BLK_W-1:0] pend_blk_q, br_blk_q, last_blk_q;
  logic [UC_W-1:0]  uop_cnt_q, n_u;
  logic [BC_W-1:0]  blk_cnt_q, n_b;
  logic [TC_W-1:0]  tk_cnt_q, n_t;
  logic [IT_W-1:0]  iter_q, iter_n;
  logic [UC_W-1:0]  len_q;
  logic             wr, closure, new_blk, over, same;

  always_comb begin
    wr      = uop_valid_i && (state_q != S_LOCK);
    closure = wr && uop_tgt_i && pend_q;
    new_blk = closure || (uop_blk_i != last_blk_q);
    n_u     = (closure ? '0 : uop_cnt_q) + UC_W'(1);
    n_b     = (closure ? '0 : blk_cnt_q) + BC_W'(new_blk);
    n_t     = (closure ? '0 : tk_cnt_q) + TC_W'(uop_taken_i);
    over    = (n_u > U_LIM) || (n_b > B_LIM) || (n_t > T_LIM) ||
              (uop_taken_i && uop_ret_i);
    same    = (pend_blk_q == br_blk_q);
    iter_n  = iter_q + IT_W'(1);
  end

  assign wr_en_o  = wr && !over && !flush_i && ((state_q == S_TRACK) || closure);
  assign wr_idx_o = closure ? '0 : uop_cnt_q[IDX_W-1:0];
  assign lock_o   = (state_q == S_LOCK);
  assign len_o    = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pend_q     <= 1'b0;
      pend_blk_q <= '0;
      br_blk_q   <= '0;
      last_blk_q <= '0;
      uop_cnt_q  <= '0;
      blk_cnt_q  <= '0;
      tk_cnt_q   <= '0;
      iter_q     <= '0;
      len_q      <= '0;
    end else if (flush_i) begin
      state_q   <= S_IDLE;
      pend_q    <= 1'b0;
      uop_cnt_q <= '0;
      blk_cnt_q <= '0;
      tk_cnt_q  <= '0;
      iter_q    <= '0;
      len_q     <= '0;
    end else begin
      if (wr) begin
        pend_q     <= uop_taken_i && !uop_ret_i;
        pend_blk_q <= uop_blk_i;
        last_blk_q <= uop_blk_i;
      end
      unique case (state_q)
        S_IDLE: if (closure && !over) begin
          state_q   <= S_TRACK;
          br_blk_q  <= pend_blk_q;
          iter_q    <= '0;
          uop_cnt_q <= n_u;
          blk_cnt_q <= n_b;
          tk_cnt_q  <= n_t;
        end
        S_TRACK: begin
          if (wr && over) begin
            state_q <= S_IDLE;   // limit broken: abandon until next closure
          end else if (wr) begin
            uop_cnt_q <= n_u;
            blk_cnt_q <= n_b;
            tk_cnt_q  <= n_t;
            if (closure) begin
              if (!same) begin
                br_blk_q <= pend_blk_q;
                iter_q   <= '0;
              end else if (iter_n >= IT_LIM) begin
                state_q <= S_LOCK;
                len_q   <= uop_cnt_q;
              end else begin
                iter_q <= iter_n;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_blk_limit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TRACK) |-> (blk_cnt_q <= B_LIM));
  assert_uop_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK) |-> (len_q <= U_LIM && len_q != '0));
  assert_taken_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TRACK) |-> (tk_cnt_q <= T_LIM));
  assert_ret_kill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && uop_taken_i && uop_ret_i) |=> (state_q == S_IDLE));
  assert_lock_on_closure_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_LOCK && !closure) |=> (state_q != S_LOCK));
  assert_flush_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (state_q == S_IDLE && !pend_q && iter_q == '0));
endmodule

// File: rtl/lsd_uop_buf.sv
module lsd_uop_buf #(
  parameter int UOP_W = 16,
  parameter int DEPTH = 28,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int LEN_W = $clog2(DEPTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [UOP_W-1:0] wr_uop_i,
  input  logic             lock_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [UOP_W-1:0] rd_uop_o
);
  logic [UOP_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] rd_q;
  logic             at_end;

  assign at_end   = (LEN_W'(rd_q) == len_i - LEN_W'(1));
  assign rd_uop_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_uop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (!lock_i) rd_q <= '0;
    else if (at_end)  rd_q <= '0;
    else              rd_q <= rd_q + IDX_W'(1);
  end

  assert_replay_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && at_end) |=> (rd_q == '0));
  assert_replay_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !at_end) |=> (!lock_i || rd_q == $past(rd_q) + IDX_W'(1)));
  assert_no_write_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> !wr_en_i);
endmodule

// File: rtl/loop_stream_detector.sv
module loop_stream_detector #(
  parameter int UOP_W      = 16,
  parameter int BLK_W      = 8,
  parameter int MAX_UOPS   = 28,
  parameter int MAX_BLOCKS = 4,
  parameter int MAX_TAKEN  = 4,
  parameter int LOCK_ITERS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             uop_valid_i,
  input  logic [UOP_W-1:0] uop_i,
  input  logic [BLK_W-1:0] uop_blk_i,
  input  logic             uop_taken_i,
  input  logic             uop_ret_i,
  input  logic             uop_tgt_i,
  output logic             gate_o,
  output logic             replay_valid_o,
  output logic [UOP_W-1:0] replay_uop_o
);
  localparam int IDX_W = $clog2(MAX_UOPS);
  localparam int UC_W  = $clog2(MAX_UOPS + 2);

  logic             lock, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [UC_W-1:0]  len;

  lsd_track #(
    .MAX_UOPS(MAX_UOPS), .MAX_BLOCKS(MAX_BLOCKS), .MAX_TAKEN(MAX_TAKEN),
    .LOCK_ITERS(LOCK_ITERS), .BLK_W(BLK_W), .IDX_W(IDX_W), .UC_W(UC_W)
  ) i_track (
    .clk_i, .rst_ni, .flush_i, .uop_valid_i, .uop_blk_i, .uop_taken_i,
    .uop_ret_i, .uop_tgt_i,
    .lock_o(lock), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .len_o(len)
  );

  lsd_uop_buf #(
    .UOP_W(UOP_W), .DEPTH(MAX_UOPS), .IDX_W(IDX_W), .LEN_W(UC_W)
  ) i_buf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_uop_i(uop_i),
    .lock_i(lock), .len_i(len), .rd_uop_o(replay_uop_o)
  );

  // flush releases the gate combinationally
  assign gate_o         = lock && !flush_i;
  assign replay_valid_o = lock && !flush_i;

  assert_flush_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !gate_o || !$past(lock));
endmodule

// File: tb/test_loop_stream_detector.sv
module test_loop_stream_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] uop = '0;
  logic [7:0]  blk = '0;
  logic        taken = 1'b0, ret = 1'b0, tgt = 1'b0;
  logic        gate, rvalid;
  logic [15:0] ruop;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  loop_stream_detector i_loop_stream_detector (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .uop_valid_i(valid),
    .uop_i(uop), .uop_blk_i(blk), .uop_taken_i(taken), .uop_ret_i(ret),
    .uop_tgt_i(tgt), .gate_o(gate), .replay_valid_o(rvalid), .replay_uop_o(ruop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit qualifies(int n, int nb, int nt, bit r);
    return (n <= 28) && (nb <= 4) && (nt <= 4) && !r;
  endfunction

  task automatic put(input logic [15:0] d, input logic [7:0] b,
                     input logic tk, input logic rt, input logic tg);
    valid = 1'b1; uop = d; blk = b; taken = tk; ret = rt; tgt = tg;
    @(negedge clk);
    valid = 1'b0; taken = 1'b0; ret = 1'b0; tgt = 1'b0;
  endtask

  // body: µop0 is the loop start, inner taken at 1..nt-1, closing branch last
  task automatic body(int n, int nb, int nt, bit r, logic [7:0] b0, logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      logic tk = (i == n - 1) || (i >= 1 && i < nt);
      put(base + 16'(i), b0 + 8'((i * nb) / n), tk, r && (i == 1), i == 0);
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic trial(string req, int n, int nb, int nt, bit r,
                       logic [7:0] b0, logic [15:0] base);
    bit q = qualifies(n, nb, nt, r);
    do_flush();
    body(n, nb, nt, r, b0, base);
    body(n, nb, nt, r, b0, base);
    body(n, nb, nt, r, b0, base);
    chk({req, " R5 no early lock"}, gate, 0);
    put(base, b0, 1'b0, 1'b0, 1'b1);
    chk(req, gate, q);
    if (q) begin
      chk("R6 replay_valid", rvalid, 1);
      for (int j = 0; j < 2 * n + 1; j++) begin
        chk("R7 replay order", ruop, base + 16'(j % n));
        valid = $urandom_range(0, 1); uop = 16'($urandom); blk = 8'($urandom);
        taken = $urandom_range(0, 1); tgt = $urandom_range(0, 1);
        @(negedge clk);
        valid = 1'b0; taken = 1'b0; tgt = 1'b0;
      end
      chk("R6 still locked", gate, 1);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R9 gate reset", gate, 0);
    chk("R9 replay_valid reset", rvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 gate after reset", gate, 0);

    trial("R2 28 uops", 28, 4, 4, 0, 8'h20, 16'h1000);
    trial("R2 29 uops", 29, 4, 4, 0, 8'h20, 16'h1100);
    trial("R1 4 blocks", 12, 4, 2, 0, 8'h40, 16'h2000);
    trial("R1 5 blocks", 12, 5, 2, 0, 8'h40, 16'h2100);
    trial("R3 4 taken", 10, 2, 4, 0, 8'h50, 16'h3000);
    trial("R3 5 taken", 10, 2, 5, 0, 8'h50, 16'h3100);
    trial("R4 return", 10, 2, 3, 1, 8'h60, 16'h4000);
    trial("R7 single uop", 1, 1, 1, 0, 8'h70, 16'h4800);

    // R8: flush during lock drops gate in the same cycle and clears tracking
    trial("R8 setup", 6, 1, 1, 0, 8'h80, 16'h5000);
    flush = 1'b1;
    #1;
    chk("R8 gate same cycle", gate, 0);
    chk("R8 replay_valid same cycle", rvalid, 0);
    @(negedge clk);
    flush = 1'b0;
    chk("R8 stays unlocked", gate, 0);
    body(6, 1, 1, 0, 8'h80, 16'h5000);
    body(6, 1, 1, 0, 8'h80, 16'h5000);
    put(16'h5000, 8'h80, 1'b0, 1'b0, 1'b1);
    chk("R8 counters cleared", gate, 0);

    // R10: closure by a new branch restarts the pass count
    do_flush();
    body(6, 2, 1, 0, 8'h10, 16'h6000);
    body(6, 2, 1, 0, 8'h10, 16'h6000);
    body(6, 2, 1, 0, 8'h90, 16'h6100);
    body(6, 2, 1, 0, 8'h90, 16'h6100);
    put(16'h6100, 8'h90, 1'b0, 1'b0, 1'b1);
    chk("R10 restart on new branch", gate, 0);
    body(6, 2, 1, 0, 8'h90, 16'h6100);
    put(16'h6100, 8'h90, 1'b0, 1'b0, 1'b1);
    chk("R10 lock after two passes", gate, 1);
    chk("R7 first replayed", ruop, 16'h6100);

    for (int t = 0; t < 40; t++) begin
      int nb = $urandom_range(1, 5);
      int nt = $urandom_range(1, 5);
      bit r  = (nt >= 2) && ($urandom_range(0, 7) == 0);
      int lo = (nb > nt + 1) ? nb : nt + 1;
      int n  = lo + $urandom_range(0, 30 - lo);
      trial("R1/R2/R3/R4 random", n, nb, nt, r, 8'($urandom_range(0, 200)),
            16'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule